// File: doc/BRIEF.md
# Receive Descriptor Write-back Engine

This block takes received Ethernet frames from a byte stream and stores them in host memory through a ring of receive descriptors. Each frame arrives as bytes marked with start and end. The total length comes with the first byte. A frame is taken in only while the receive-enable input is high. For each frame the engine first reads the descriptor at the current ring pointer: the control word, the size word and the buffer address. It then packs the frame bytes little-endian into 32-bit memory writes at the buffer address. Next it writes a completion word back over the descriptor's control word and moves the ring pointer on.

A frame shorter than the minimum length is consumed and dropped before any descriptor access. A frame that finds a descriptor the host does not own is consumed and discarded. Each outcome raises its own sticky status flags. Stored frames update a byte total and a frame total. The destination address is also classed, and multicast and broadcast frames have their own counters.

The controller is one state machine with eight states:
- `S_IDLE` waits for a frame start. It goes to `S_DISCARD` for a short frame, or to `S_FETCH_CTL` for any other frame.
- `S_FETCH_CTL`, `S_FETCH_SIZE` and `S_FETCH_BUF` each issue one descriptor word read. Read data returns one cycle later.
- `S_FETCH_SIZE` checks the ownership bit. It goes to `S_DISCARD` if the bit is clear, or to `S_FETCH_BUF` if it is set.
- `S_LATCH_BUF` captures the buffer address and then goes to `S_STORE`.
- `S_STORE` accepts bytes until the end byte, then goes to `S_WRITEBACK`.
- `S_WRITEBACK` writes the completion word, advances the pointer and returns to `S_IDLE`.
- `S_DISCARD` consumes bytes up to the end byte and returns to `S_IDLE`.

Top module: `rxdesc_wb`

## Requirements
- R1: `in_ready` is low whenever no frame is in progress. A frame starts only if `rx_en` is 1 while `in_valid` and `in_sof` are high, so with `rx_en` at 0 the stream is held and nothing changes.
- R2: A frame whose `in_len` is below 12 is consumed with no memory write. It sets status bits 0 (frame received) and 1 (normal summary), and leaves the counters and pointer unchanged.
- R3: If bit 31 of descriptor word 0 (the ownership bit, at pointer + 0) is clear, the frame is consumed with no write. It sets status bits 2 (no descriptor) and 3 (abnormal summary), and leaves the pointer and counters unchanged.
- R4: A stored frame's byte i goes to byte address buffer + i, where the buffer address is descriptor word 2 (pointer + 8). Bytes are packed little-endian into 32-bit writes. A final partial word writes only its low byte lanes, so memory bytes past the frame keep their values.
- R5: After storing, descriptor word 0 holds ((in_len + 4) << 16) | 0x300, which leaves the ownership bit clear.
- R6: `base_wr` loads both the ring base and `cur_ptr`. After each stored frame, `cur_ptr` reloads the base if bit 15 of descriptor word 1 (pointer + 4) is set. Otherwise it advances by 32.
- R7: Byte 0 of the destination with bit 0 clear makes the frame unicast. Six 0xFF destination bytes make it broadcast (`cnt_bcast` + 1). Any other frame is multicast (`cnt_mcast` + 1).
- R8: Each stored frame adds in_len + 4 to `cnt_bytes` and 1 to `cnt_frames`.
- R9: A stored frame sets status bits 0 and 1.
- R10: Status bits are sticky. A 1 on a bit of `stat_clr` clears that bit only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| base_wr | input | 1 | Load ring base and current pointer |
| base_addr | input | ADDR_W | Ring base value |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_data | input | 8 | Stream byte |
| in_len | input | LEN_W | Frame length, valid with the first byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| stat_o | output | 4 | Sticky status: 0 received, 1 normal, 2 no descriptor, 3 abnormal |
| stat_clr | input | 4 | Write-one-to-clear for status |
| cur_ptr | output | ADDR_W | Current descriptor pointer |
| cnt_bytes | output | CNT_W | Stored byte total including 4 per frame |
| cnt_frames | output | CNT_W | Stored frame total |
| cnt_mcast | output | CNT_W | Multicast frame total |
| cnt_bcast | output | CNT_W | Broadcast frame total |

## Verification
The bound checker watches several rules on every cycle:
- the input is held while idle;
- no write happens during a discard;
- byte enables are contiguous from lane 0;
- the pointer moves only by 32 or back to the base;
- the byte and frame counters move together;
- at most one class counter steps at a time;
- status flags are set after each write-back.

Only the bench's scenarios can show the data that matters: the buffer contents, the completion word, the bytes left untouched past a partial word, and the exact count and class values. They also cover the three frame outcomes, which are short, unowned and stored.

// File: rtl/rxdesc_pkg.sv
package rxdesc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_CTL,
        S_FETCH_SIZE,
        S_FETCH_BUF,
        S_LATCH_BUF,
        S_STORE,
        S_WRITEBACK,
        S_DISCARD
    } rx_state_e;

    localparam int ST_RXDONE   = 0;
    localparam int ST_NORMAL   = 1;
    localparam int ST_NODESC   = 2;
    localparam int ST_ABNORMAL = 3;
    localparam int ST_W        = 4;

    localparam int OWN_BIT  = 31;
    localparam int WRAP_BIT = 15;
    localparam logic [31:0] DONE_PATTERN = 32'h0000_0300;

endpackage

// File: rtl/rxdesc_lane_pack.sv
module rxdesc_lane_pack #(
    parameter int LANES  = 4,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANES*8-1:0] held,
    input  logic [LANE_W-1:0]  lane,
    input  logic [7:0]         din,
    output logic [LANES*8-1:0] wdata,
    output logic [LANES-1:0]   be
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign wdata[l*8 +: 8] = (LANE_W'(l) == lane) ? din : held[l*8 +: 8];
        assign be[l]           = (LANE_W'(l) <= lane);
    end
endmodule

// File: rtl/rxdesc_dest_class.sv
module rxdesc_dest_class #(
    parameter int HDR_BYTES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       byte_en,
    input  logic [2:0] idx,
    input  logic [7:0] din,
    output logic       is_bcast,
    output logic       is_mcast
);
    logic group_bit;
    logic all_ones;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            group_bit <= 1'b0;
            all_ones  <= 1'b0;
        end else if (clear) begin
            group_bit <= 1'b0;
            all_ones  <= 1'b1;
        end else if (byte_en && (int'(idx) < HDR_BYTES)) begin
            if (idx == 3'd0) group_bit <= din[0];
            all_ones <= all_ones && (din == 8'hFF);
        end
    end

    assign is_bcast = all_ones;
    assign is_mcast = group_bit && !all_ones;
endmodule

// File: rtl/rxdesc_stats.sv
module rxdesc_stats #(
    parameter int CNT_W = 64,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [LEN_W-1:0] len,
    input  logic             bcast,
    input  logic             mcast,
    output logic [CNT_W-1:0] bytes_tot,
    output logic [CNT_W-1:0] frames_tot,
    output logic [CNT_W-1:0] mcast_tot,
    output logic [CNT_W-1:0] bcast_tot
);
    localparam logic [CNT_W-1:0] CRC_BYTES = CNT_W'(4);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_tot  <= '0;
            frames_tot <= '0;
            mcast_tot  <= '0;
            bcast_tot  <= '0;
        end else if (commit) begin
            bytes_tot  <= bytes_tot + CNT_W'(len) + CRC_BYTES;
            frames_tot <= frames_tot + 1'b1;
            if (mcast) mcast_tot <= mcast_tot + 1'b1;
            else if (bcast) bcast_tot <= bcast_tot + 1'b1;
        end
    end
endmodule

// File: rtl/rxdesc_wb.sv
module rxdesc_wb
    import rxdesc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int CNT_W      = 64,
    parameter int DESC_BYTES = 32,
    parameter int MIN_LEN    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    input  logic [LEN_W-1:0]  in_len,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic [31:0]       mem_rdata,
    output logic [ST_W-1:0]   stat_o,
    input  logic [ST_W-1:0]   stat_clr,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic [CNT_W-1:0]  cnt_bytes,
    output logic [CNT_W-1:0]  cnt_frames,
    output logic [CNT_W-1:0]  cnt_mcast,
    output logic [CNT_W-1:0]  cnt_bcast
);
    localparam logic [ADDR_W-1:0] OFS_SIZE = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_BUF  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(DESC_BYTES);

    rx_state_e state, nstate;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] buf_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  bcnt;
    logic [31:0]       held;
    logic              wrap_q;
    logic [ST_W-1:0]   stat_set;

    logic        take;
    logic        start_ok;
    logic        runt;
    logic        word_done;
    logic [31:0] pack_data;
    logic [3:0]  pack_be;
    logic [31:0] wb_word;
    logic [2:0]  hdr_idx;
    logic        is_bcast, is_mcast;

    assign take      = in_valid && in_ready;
    assign start_ok  = (state == S_IDLE) && rx_en && in_valid && in_sof;
    assign runt      = (in_len < LEN_W'(MIN_LEN));
    assign word_done = (bcnt[1:0] == 2'd3) || in_eof;
    assign wb_word   = ((32'(len_q) + 32'd4) << 16) | DONE_PATTERN;
    assign hdr_idx   = (bcnt < LEN_W'(6)) ? bcnt[2:0] : 3'd7;

    rxdesc_lane_pack #(.LANES(4)) u_pack (
        .held  (held),
        .lane  (bcnt[1:0]),
        .din   (in_data),
        .wdata (pack_data),
        .be    (pack_be)
    );

    rxdesc_dest_class #(.HDR_BYTES(6)) u_class (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_ok),
        .byte_en  ((state == S_STORE) && take),
        .idx      (hdr_idx),
        .din      (in_data),
        .is_bcast (is_bcast),
        .is_mcast (is_mcast)
    );

    rxdesc_stats #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (state == S_WRITEBACK),
        .len        (len_q),
        .bcast      (is_bcast),
        .mcast      (is_mcast),
        .bytes_tot  (cnt_bytes),
        .frames_tot (cnt_frames),
        .mcast_tot  (cnt_mcast),
        .bcast_tot  (cnt_bcast)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:       if (start_ok) nstate = runt ? S_DISCARD : S_FETCH_CTL;
            S_FETCH_CTL:  nstate = S_FETCH_SIZE;
            S_FETCH_SIZE: nstate = mem_rdata[OWN_BIT] ? S_FETCH_BUF : S_DISCARD;
            S_FETCH_BUF:  nstate = S_LATCH_BUF;
            S_LATCH_BUF:  nstate = S_STORE;
            S_STORE:      if (take && in_eof) nstate = S_WRITEBACK;
            S_WRITEBACK:  nstate = S_IDLE;
            S_DISCARD:    if (take && in_eof) nstate = S_IDLE;
            default:      nstate = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        stat_set  = '0;
        unique case (state)
            S_IDLE: begin
                if (start_ok && runt) begin
                    stat_set[ST_RXDONE] = 1'b1;
                    stat_set[ST_NORMAL] = 1'b1;
                end
            end
            S_FETCH_CTL: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr;
            end
            S_FETCH_SIZE: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + OFS_SIZE;
                if (!mem_rdata[OWN_BIT]) begin
                    stat_set[ST_NODESC]   = 1'b1;
                    stat_set[ST_ABNORMAL] = 1'b1;
                end
            end
            S_FETCH_BUF: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + OFS_BUF;
            end
            S_LATCH_BUF: ;
            S_STORE: begin
                in_ready = 1'b1;
                if (in_valid && word_done) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = buf_q + ADDR_W'({bcnt[LEN_W-1:2], 2'b00});
                    mem_wdata = pack_data;
                    mem_be    = pack_be;
                end
            end
            S_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr;
                mem_wdata = wb_word;
                mem_be    = 4'hF;
                stat_set[ST_RXDONE] = 1'b1;
                stat_set[ST_NORMAL] = 1'b1;
            end
            S_DISCARD: in_ready = 1'b1;
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            cur_ptr <= '0;
            buf_q   <= '0;
            len_q   <= '0;
            bcnt    <= '0;
            held    <= '0;
            wrap_q  <= 1'b0;
            stat_o  <= '0;
        end else begin
            stat_o <= (stat_o & ~stat_clr) | stat_set;
            if (start_ok) begin
                len_q <= in_len;
                bcnt  <= '0;
            end
            if (state == S_FETCH_BUF) wrap_q <= mem_rdata[WRAP_BIT];
            if (state == S_LATCH_BUF) buf_q  <= mem_rdata[ADDR_W-1:0];
            if ((state == S_STORE) && take) begin
                held[bcnt[1:0]*8 +: 8] <= in_data;
                bcnt <= bcnt + 1'b1;
            end
            if (base_wr) begin
                base_q  <= base_addr;
                cur_ptr <= base_addr;
            end else if (state == S_WRITEBACK) begin
                cur_ptr <= wrap_q ? base_q : cur_ptr + STEP;
            end
        end
    end
endmodule

// File: rtl/rxdesc_wb_chk.sv
module rxdesc_wb_chk
    import rxdesc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 64,
    parameter int DESC_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input rx_state_e         state,
    input logic              in_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [3:0]        mem_be,
    input logic              base_wr,
    input logic [ADDR_W-1:0] base_q,
    input logic [ADDR_W-1:0] cur_ptr,
    input logic [ST_W-1:0]   stat_o,
    input logic [CNT_W-1:0]  cnt_bytes,
    input logic [CNT_W-1:0]  cnt_frames,
    input logic [CNT_W-1:0]  cnt_mcast,
    input logic [CNT_W-1:0]  cnt_bcast
);
    AST_IDLE_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !in_ready); // R1

    AST_DISCARD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DISCARD) |-> !(mem_req && mem_we)); // R2

    AST_BE_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be inside {4'h1, 4'h3, 4'h7, 4'hF})); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !base_wr |=> ((cur_ptr == $past(cur_ptr)) ||
                      (cur_ptr == $past(cur_ptr) + ADDR_W'(DESC_BYTES)) ||
                      (cur_ptr == base_q))); // R6

    AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones({cnt_mcast != $past(cnt_mcast),
                               cnt_bcast != $past(cnt_bcast)}) <= 1)); // R7

    AST_COUNTERS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((cnt_frames != $past(cnt_frames)) == (cnt_bytes != $past(cnt_bytes)))); // R8

    AST_STATUS_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITEBACK) |=> (stat_o[ST_RXDONE] && stat_o[ST_NORMAL])); // R9
endmodule

bind rxdesc_wb rxdesc_wb_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DESC_BYTES(DESC_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .base_wr(base_wr), .base_q(base_q), .cur_ptr(cur_ptr), .stat_o(stat_o),
    .cnt_bytes(cnt_bytes), .cnt_frames(cnt_frames),
    .cnt_mcast(cnt_mcast), .cnt_bcast(cnt_bcast)
);

// File: tb/tb_rxdesc_wb.sv
module tb_rxdesc_wb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int CNT_W  = 64;
    localparam logic [31:0] RING_BASE = 32'h0000_0100;
    localparam logic [31:0] BUF_BASE  = 32'h0000_0400;
    localparam int RING_N = 4;
    localparam logic [31:0] FILL = 32'hA5A5_A5A5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0;
    logic base_wr = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic in_ready;
    logic [7:0] in_data = '0;
    logic [LEN_W-1:0] in_len = '0;
    logic mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0] mem_be;
    logic [31:0] mem_rdata = '0;
    logic [3:0] stat_o;
    logic [3:0] stat_clr = '0;
    logic [ADDR_W-1:0] cur_ptr;
    logic [CNT_W-1:0] cnt_bytes, cnt_frames, cnt_mcast, cnt_bcast;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxdesc_wb dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .base_wr(base_wr), .base_addr(base_addr),
        .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .in_len(in_len), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
        .stat_o(stat_o), .stat_clr(stat_clr), .cur_ptr(cur_ptr), .cnt_bytes(cnt_bytes),
        .cnt_frames(cnt_frames), .cnt_mcast(cnt_mcast), .cnt_bcast(cnt_bcast)
    );

    // Memory model with a back-door write port for the bench
    logic [31:0] mem [0:1023];
    logic poke_en = 1'b0;
    logic [31:0] poke_addr = '0, poke_data = '0;

    always @(posedge clk) begin
        if (poke_en) mem[poke_addr[11:2]] <= poke_data;
        else if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end else mem_rdata <= mem[mem_addr[11:2]];
        end
    end

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] fb [0:63];
    logic [31:0] exp_ptr;
    logic [63:0] e_bytes = 0, e_frames = 0, e_mcast = 0, e_bcast = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    function automatic logic [7:0] peek_byte(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[11:2]];
        return w[a[1:0]*8 +: 8];
    endfunction

    function automatic logic [31:0] done_word(input int len);
        return ((32'(len) + 32'd4) << 16) | 32'h0000_0300;
    endfunction

    // 0 unicast, 1 broadcast, 2 multicast
    function automatic int dest_kind(input int len);
        bit all_ff;
        all_ff = 1'b1;
        for (int i = 0; i < 6; i++) if (fb[i] != 8'hFF) all_ff = 1'b0;
        if (len < 6) return 0;
        if (all_ff) return 1;
        if (fb[0][0] == 1'b0) return 0;
        return 2;
    endfunction

    task automatic build_frame(input int kind, input int len);
        for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
        if (kind == 0) fb[0][0] = 1'b0;
        else if (kind == 1) for (int i = 0; i < 6; i++) fb[i] = 8'hFF;
        else begin fb[0][0] = 1'b1; fb[5] = 8'h00; end
    endtask

    task automatic send_frame(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
            in_data = fb[i]; in_len = LEN_W'(len);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_status(input logic [3:0] m);
        @(negedge clk); stat_clr = m;
        @(negedge clk); stat_clr = '0;
    endtask

    function automatic int ring_idx(input logic [31:0] p);
        return int'((p - RING_BASE) >> 5);
    endfunction

    task automatic arm_desc(input logic [31:0] p, input logic [31:0] ctl);
        int idx;
        logic [31:0] bufa;
        idx = ring_idx(p);
        bufa = BUF_BASE + 32'(idx * 128);
        poke(p, ctl);
        poke(p + 4, (idx == RING_N - 1) ? 32'h0000_8080 : 32'h0000_0080);
        poke(p + 8, bufa);
        for (int w = 0; w < 17; w++) poke(bufa + 32'(w * 4), FILL);
    endtask

    task automatic check_counters();
        chk("R8 cnt_bytes", cnt_bytes, e_bytes);
        chk("R8 cnt_frames", cnt_frames, e_frames);
        chk("R7 cnt_mcast", cnt_mcast, e_mcast);
        chk("R7 cnt_bcast", cnt_bcast, e_bcast);
    endtask

    task automatic run_good(input int kind, input int len);
        int idx, bad, k;
        logic [31:0] bufa;
        idx = ring_idx(exp_ptr);
        bufa = BUF_BASE + 32'(idx * 128);
        arm_desc(exp_ptr, 32'h8000_0000);
        build_frame(kind, len);
        send_frame(len);
        chk("R5 completion word", mem[exp_ptr[11:2]], done_word(len));
        bad = 0;
        for (int i = 0; i < len; i++) if (peek_byte(bufa + 32'(i)) !== fb[i]) bad++;
        chk("R4 buffer bytes mismatched", 64'(bad), 64'd0);
        if (len % 4 != 0) chk("R4 byte past end untouched", peek_byte(bufa + 32'(len)), 8'hA5);
        e_bytes += 64'(len + 4);
        e_frames += 1;
        k = dest_kind(len);
        if (k == 1) e_bcast += 1;
        else if (k == 2) e_mcast += 1;
        exp_ptr = (idx == RING_N - 1) ? RING_BASE : exp_ptr + 32'd32;
        check_counters();
        chk("R6 cur_ptr", cur_ptr, exp_ptr);
        chk("R9 status after store", stat_o, 4'b0011);
        clear_status(4'hF);
        chk("R10 status cleared", stat_o, 4'b0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        int hold_ready, lenr, kindr;
        logic [31:0] bufa;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset in_ready", in_ready, 0);
        chk("R10 reset status", stat_o, 0);
        chk("R8 reset frames", cnt_frames, 0);
        chk("R6 reset ptr", cur_ptr, 0);

        // Ring base load
        base_addr = RING_BASE; base_wr = 1'b1;
        @(negedge clk); base_wr = 1'b0;
        exp_ptr = RING_BASE;
        chk("R6 base load", cur_ptr, RING_BASE);

        // R1: held while disabled
        arm_desc(exp_ptr, 32'h8000_0000);
        build_frame(0, 16);
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b0; in_data = fb[0]; in_len = 16;
        hold_ready = 0;
        for (int c = 0; c < 10; c++) begin @(negedge clk); #1; if (in_ready) hold_ready++; end
        chk("R1 ready stays low while disabled", 64'(hold_ready), 0);
        chk("R1 descriptor untouched while disabled", mem[exp_ptr[11:2]], 32'h8000_0000);
        chk("R1 frames unchanged while disabled", cnt_frames, 0);
        in_valid = 1'b0; in_sof = 1'b0;
        rx_en = 1'b1;
        run_good(0, 16);

        // R2: short frames, length 8 and 11
        for (int r = 0; r < 2; r++) begin
            lenr = (r == 0) ? 8 : 11;
            arm_desc(exp_ptr, 32'h8000_0000);
            bufa = BUF_BASE + 32'(ring_idx(exp_ptr) * 128);
            build_frame(0, lenr);
            send_frame(lenr);
            chk("R2 status on short frame", stat_o, 4'b0011);
            chk("R2 descriptor untouched", mem[exp_ptr[11:2]], 32'h8000_0000);
            chk("R2 buffer untouched", mem[bufa[11:2]], FILL);
            chk("R2 ptr unchanged", cur_ptr, exp_ptr);
            check_counters();
            clear_status(4'hF);
        end
        // Boundary: exactly 12 bytes is stored
        run_good(1, 12);

        // R3: descriptor not owned
        arm_desc(exp_ptr, 32'h0000_0000);
        bufa = BUF_BASE + 32'(ring_idx(exp_ptr) * 128);
        build_frame(2, 20);
        send_frame(20);
        chk("R3 status on missing descriptor", stat_o, 4'b1100);
        chk("R3 descriptor untouched", mem[exp_ptr[11:2]], 32'h0000_0000);
        chk("R3 buffer untouched", mem[bufa[11:2]], FILL);
        chk("R3 ptr unchanged", cur_ptr, exp_ptr);
        check_counters();
        clear_status(4'hF);

        // R10: partial clear keeps other bits
        arm_desc(exp_ptr, 32'h0000_0000);
        build_frame(0, 14);
        send_frame(14);
        clear_status(4'b0100);
        chk("R10 clear only bit 2", stat_o, 4'b1000);
        clear_status(4'hF);

        // Partial last word lengths and classes
        run_good(2, 13);
        run_good(1, 14);
        run_good(0, 15);

        // Random traffic, wraps the ring several times
        for (int n = 0; n < 30; n++) begin
            kindr = int'($urandom % 3);
            lenr = 12 + int'($urandom % 49);
            run_good(kindr, lenr);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule